// File: doc/BRIEF.md
# Byte-Lane Data Word Packer

This block sits between a word-wide host data register and a byte-serial two-wire bus engine. In transmit commands the host (software or a DMA channel) writes full words. The block hands their bytes to the engine one at a time, starting with the lowest lane. The total byte count of the command includes the address byte, which travels in lane 0 of the first word. When that count is not a multiple of the lane count, only the low lanes of the final word are sent, and its upper lanes are never presented. In receive commands each byte taken from the engine appears zero-extended in the low lane of the read-data word.

A single sticky request flag, shown in the top bit of a status word, tells the host that the block wants its next transmit word or has a received byte ready. The host deasserts it by writing the clear alias with the top bit set. A new command flushes any held word and restarts at lane 0.

Top module: `bytelane_packer`

## Requirements
- R1: After a synchronous reset the request flag is low, the engine sees no valid transmit byte, and the read-data word is zero.
- R2: A transmit word's bytes reach the engine in lane order, bits 7:0 first, then 15:8, 23:16 and 31:24. One byte moves per cycle in which `eng_tx_valid` and `eng_tx_ready` are both high, and the offered byte holds steady while the engine stalls.
- R3: A transmit command with byte count N (the address byte included, as byte 0) delivers exactly N bytes. `eng_tx_last` is high only while byte N-1 is offered.
- R4: When N is not a multiple of 4, the final word contributes only its N mod 4 low lanes, and its remaining lanes are never offered.
- R5: The request flag rises one cycle after a transmit command with N greater than 0 starts, and one cycle after the last lane of a word is taken while bytes are still owed. It does not rise when the final word drains.
- R6: Once high, the request flag stays high until a clear write with bit 31 = 1. A clear write with bit 31 = 0 has no effect.
- R7: If a set event and a clear write with bit 31 = 1 fall in the same cycle, the flag is high afterwards.
- R8: A word written while no request is pending is accepted and held. The request flag stays low until that word's last lane has been taken.
- R9: A write is ignored while a word is already held, and also when the command owes no further bytes (idle or receive).
- R10: Starting a command drops any held word, so the engine sees no valid byte in the next cycle, and the next word starts at lane 0.
- R11: In a receive command of count N, each of the first N bytes from the engine appears in bits 7:0 of the read-data word, with the upper bits zero, and sets the request flag. Bytes beyond N leave both the read-data word and the flag unchanged.
- R12: The status word carries the request flag in bit 31, and all its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | One-cycle pulse that begins a command |
| cmd_tx | input | 1 | Command direction: 1 = transmit, 0 = receive |
| cmd_count | input | 16 | Byte count of the command (the address byte included for transmit) |
| host_wr | input | 1 | Write strobe for the data register |
| host_wdata | input | 32 | Transmit word written by the host |
| host_rdata | output | 32 | Read-data word with the last received byte in bits 7:0 |
| clr_wr | input | 1 | Write strobe for the status clear alias |
| clr_bit | input | 1 | Bit 31 of the word written to the clear alias |
| stat_word | output | 32 | Status word, with the request flag in bit 31 |
| eng_tx_valid | output | 1 | A transmit byte is offered to the engine |
| eng_tx_byte | output | 8 | Offered transmit byte |
| eng_tx_last | output | 1 | The offered byte is the last of the command |
| eng_tx_ready | input | 1 | The engine takes the offered byte this cycle |
| eng_rx_valid | input | 1 | The engine delivers a received byte this cycle |
| eng_rx_byte | input | 8 | Received byte |

## Verification
Setting and clearing of the request flag can fall in the same cycle. A set comes from the engine taking the last lane of a word or from a received byte, and a clear comes from the host writing the alias. The bench provokes the collision on purpose in two ways: it writes the clear alias in the cycle a received byte arrives, and it drives random clear writes against a randomly stalling engine during transmit. The behavioural model applies set over clear, and it is compared with the flag and with every engine and read-data output on each clock.

// File: rtl/bytelane_pkg.sv
// Shared types and helper functions for the byte-lane packer.
// Assumes the word width is a whole multiple of the byte width.
package bytelane_pkg;

    // Direction of a command as seen on cmd_tx.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } xfer_dir_e;

    // Number of byte lanes in one word.
    function automatic int lane_count(input int word_w, input int byte_w);
        return word_w / byte_w;
    endfunction

    // Width of a lane index, at least one bit.
    function automatic int lane_idx_w(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/blp_tx_unpack.sv
// Transmit side: holds a single host word and offers its lanes to the
// engine lowest lane first. It counts the bytes still to be fetched, so
// the last word is cut to the lanes actually owed.
// Assumes: cmd_start has priority over every other input in its cycle.
module blp_tx_unpack
    import bytelane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_tx,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              need_word
);

    localparam int LANES  = lane_count(WORD_W, BYTE_W);
    localparam int LANE_W = lane_idx_w(LANES);

    logic [CNT_W-1:0]  fetch_left;
    logic              buf_full;
    logic [WORD_W-1:0] buf_word;
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] last_lane;
    logic [CNT_W-1:0]  take_n;
    logic [LANE_W-1:0] load_last;
    logic              load;
    logic              consume;
    logic              at_last_lane;
    logic [BYTE_W-1:0] lane_bytes [LANES];

    // Split the held word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = buf_word[g*BYTE_W +: BYTE_W];
    end

    // Size of the next load: a full word, or the bytes still owed.
    always_comb begin
        if (fetch_left >= CNT_W'(LANES)) begin
            take_n    = CNT_W'(LANES);
            load_last = LANE_W'(LANES - 1);
        end else begin
            take_n    = fetch_left;
            load_last = LANE_W'(fetch_left - 1'b1);
        end
    end

    assign load         = wr_en && !buf_full && (fetch_left != '0) && !cmd_start;
    assign consume      = buf_full && tx_ready && !cmd_start;
    assign at_last_lane = (lane == last_lane);

    // Word buffer, lane pointer and fetch counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_left <= '0;
            buf_full   <= 1'b0;
            buf_word   <= '0;
            lane       <= '0;
            last_lane  <= '0;
        end else if (cmd_start) begin
            fetch_left <= cmd_tx ? cmd_count : '0;
            buf_full   <= 1'b0;
            lane       <= '0;
        end else if (load) begin
            buf_word   <= wr_data;
            buf_full   <= 1'b1;
            lane       <= '0;
            last_lane  <= load_last;
            fetch_left <= fetch_left - take_n;
        end else if (consume) begin
            if (at_last_lane) begin
                buf_full <= 1'b0;
            end else begin
                lane <= lane + 1'b1;
            end
        end
    end

    assign tx_valid  = buf_full;
    assign tx_byte   = lane_bytes[lane];
    assign tx_last   = buf_full && at_last_lane && (fetch_left == '0);
    assign need_word = consume && at_last_lane && (fetch_left != '0);

    AST_LANE_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> (lane <= last_lane)); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !cmd_start) |=> (tx_valid && $stable(tx_byte))); // R2
    AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!tx_valid && lane == '0)); // R10
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && wr_en && !cmd_start) |=> $stable(buf_word)); // R9

endmodule

// File: rtl/blp_rx_pack.sv
// Receive side: places each accepted engine byte zero-extended in the
// low lane of the read-data word, accepting up to the command's count.
// Assumes: a receive byte in a cmd_start cycle is discarded.
module blp_rx_pack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_tx,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [WORD_W-1:0] rdata,
    output logic              rx_got
);

    logic [CNT_W-1:0] rx_left;

    assign rx_got = rx_valid && (rx_left != '0) && !cmd_start;

    // Receive byte counter and read-data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_left <= '0;
            rdata   <= '0;
        end else if (cmd_start) begin
            rx_left <= cmd_tx ? '0 : cmd_count;
        end else if (rx_got) begin
            rx_left <= rx_left - 1'b1;
            rdata   <= WORD_W'(rx_byte);
        end
    end

    AST_RX_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_got |=> (rdata == WORD_W'($past(rx_byte)))); // R11
    AST_RX_BEYOND_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_left == '0 && !cmd_start) |=> $stable(rdata)); // R11

endmodule

// File: rtl/blp_req_flag.sv
// Sticky request flag. A set event raises it and a host clear lowers it.
// A set in the same cycle beats the clear, and a command start reloads it.
// Assumes: set_evt is already gated off in cmd_start cycles.
module blp_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_set,
    input  logic set_evt,
    input  logic clr_evt,
    output logic req
);

    // Flag update: start reload, then set over clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (start) begin
            req <= start_set;
        end else if (set_evt) begin
            req <= 1'b1;
        end else if (clr_evt) begin
            req <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !start) |=> req); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt && !start) |=> !req); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr_evt && !start) |=> req); // R6

endmodule

// File: rtl/bytelane_packer.sv
// Top level: joins the transmit unpacker, the receive packer and the
// request flag, and builds the status word.
// Assumes: one command is active at a time, started by cmd_start.
module bytelane_packer
    import bytelane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_tx,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              clr_wr,
    input  logic              clr_bit,
    output logic [WORD_W-1:0] stat_word,
    output logic              eng_tx_valid,
    output logic [BYTE_W-1:0] eng_tx_byte,
    output logic              eng_tx_last,
    input  logic              eng_tx_ready,
    input  logic              eng_rx_valid,
    input  logic [BYTE_W-1:0] eng_rx_byte
);

    localparam int REQ_BIT = WORD_W - 1;

    logic need_word;
    logic rx_got;
    logic req;
    logic start_set;
    logic clr_evt;

    assign start_set = (xfer_dir_e'(cmd_tx) == DIR_TX) && (cmd_count != '0);
    assign clr_evt   = clr_wr && clr_bit;

    blp_tx_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_tx    (cmd_tx),
        .cmd_count (cmd_count),
        .wr_en     (host_wr),
        .wr_data   (host_wdata),
        .tx_valid  (eng_tx_valid),
        .tx_byte   (eng_tx_byte),
        .tx_last   (eng_tx_last),
        .tx_ready  (eng_tx_ready),
        .need_word (need_word)
    );

    blp_rx_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_tx    (cmd_tx),
        .cmd_count (cmd_count),
        .rx_valid  (eng_rx_valid),
        .rx_byte   (eng_rx_byte),
        .rdata     (host_rdata),
        .rx_got    (rx_got)
    );

    blp_req_flag u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .start_set (start_set),
        .set_evt   (need_word || rx_got),
        .clr_evt   (clr_evt),
        .req       (req)
    );

    // Status word: the flag in the top bit, zeros elsewhere.
    always_comb begin
        stat_word          = '0;
        stat_word[REQ_BIT] = req;
    end

    AST_TX_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(need_word && rx_got)); // R7
    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_tx && cmd_count != '0) |=> stat_word[REQ_BIT]); // R5

endmodule

// File: tb/bytelane_packer_tb.sv
module bytelane_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_tx = 1'b0;
    logic [15:0] cmd_count = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        clr_wr = 1'b0;
    logic        clr_bit = 1'b0;
    logic [31:0] stat_word;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_last;
    logic        eng_tx_ready = 1'b0;
    logic        eng_rx_valid = 1'b0;
    logic [7:0]  eng_rx_byte = '0;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Behavioural reference model state.
    logic [7:0]  m_q[$];
    int          m_fetch = 0;
    int          m_rxleft = 0;
    bit          m_req = 1'b0;
    logic [31:0] m_rd = '0;

    // Bytes taken by the engine and the position of the last flag.
    logic [7:0]  cap[$];
    int          last_idx = -1;

    always #2 clk = ~clk;

    bytelane_packer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_tx       (cmd_tx),
        .cmd_count    (cmd_count),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .clr_wr       (clr_wr),
        .clr_bit      (clr_bit),
        .stat_word    (stat_word),
        .eng_tx_valid (eng_tx_valid),
        .eng_tx_byte  (eng_tx_byte),
        .eng_tx_last  (eng_tx_last),
        .eng_tx_ready (eng_tx_ready),
        .eng_rx_valid (eng_rx_valid),
        .eng_rx_byte  (eng_rx_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: advances on each clock from the applied inputs.
    always @(posedge clk) begin
        bit set;
        if (!rst_n) begin
            m_q.delete();
            m_fetch = 0; m_rxleft = 0; m_req = 1'b0; m_rd = '0;
        end else if (cmd_start) begin
            m_q.delete();
            m_fetch  = cmd_tx ? int'(cmd_count) : 0;
            m_rxleft = cmd_tx ? 0 : int'(cmd_count);
            m_req    = cmd_tx && (cmd_count != 0);
        end else begin
            set = 1'b0;
            if (m_q.size() > 0) begin
                if (eng_tx_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0 && m_fetch > 0) set = 1'b1;
                end
            end else if (host_wr && m_fetch > 0) begin
                int n;
                n = (m_fetch > 4) ? 4 : m_fetch;
                for (int k = 0; k < n; k++) m_q.push_back(host_wdata[8*k +: 8]);
                m_fetch -= n;
            end
            if (eng_rx_valid && m_rxleft > 0) begin
                m_rd = {24'h0, eng_rx_byte};
                m_rxleft--;
                set = 1'b1;
            end
            m_req = set || (m_req && !(clr_wr && clr_bit));
        end
    end

    // Engine-side monitor of accepted bytes.
    always @(posedge clk) begin
        if (rst_n && !cmd_start && eng_tx_valid && eng_tx_ready) begin
            if (eng_tx_last) last_idx = cap.size();
            cap.push_back(eng_tx_byte);
        end
    end

    // Per-clock comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8 tx_valid", {31'h0, eng_tx_valid}, {31'h0, m_q.size() > 0});
            if (m_q.size() > 0) chk("R2 tx_byte", {24'h0, eng_tx_byte}, {24'h0, m_q[0]});
            chk("R3 tx_last", {31'h0, eng_tx_last}, {31'h0, (m_q.size() == 1 && m_fetch == 0)});
            chk("R6 req", {31'h0, stat_word[31]}, {31'h0, m_req});
            chk("R12 stat", stat_word, {m_req, 31'h0});
            chk("R11 rdata", host_rdata, m_rd);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        cmd_start = 1'b0; host_wr = 1'b0; clr_wr = 1'b0; clr_bit = 1'b0; eng_rx_valid = 1'b0;
    endtask

    task automatic start(input logic tx, input logic [15:0] cnt);
        tick(); cmd_start = 1'b1; cmd_tx = tx; cmd_count = cnt;
    endtask

    task automatic wr(input logic [31:0] w);
        tick(); host_wr = 1'b1; host_wdata = w;
    endtask

    task automatic clr(input logic b);
        tick(); clr_wr = 1'b1; clr_bit = b;
    endtask

    task automatic rx(input logic [7:0] b);
        tick(); eng_rx_valid = 1'b1; eng_rx_byte = b;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && eng_tx_valid; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 req", {31'h0, stat_word[31]}, 32'h0);
        chk("R1 tx_valid", {31'h0, eng_tx_valid}, 32'h0);
        chk("R1 rdata", host_rdata, 32'h0);
        cmp_on = 1'b1;

        // Six-byte write: a full word, then a word with two live lanes.
        eng_tx_ready = 1'b1;
        start(1'b1, 16'd6);
        tick();
        chk("R5 req after start", {31'h0, stat_word[31]}, 32'h1);
        wr(32'h3322_11A0); clr_wr = 1'b1; clr_bit = 1'b1;
        tick();
        chk("R6 cleared", {31'h0, stat_word[31]}, 32'h0);
        for (int i = 0; i < 20 && !stat_word[31]; i++) tick();
        chk("R5 req after drain", {31'h0, stat_word[31]}, 32'h1);
        chk("R2 lane0", {24'h0, cap[0]}, 32'hA0);
        chk("R2 lane3", {24'h0, cap[3]}, 32'h33);
        wr(32'hDEAD_BE55); clr_wr = 1'b1; clr_bit = 1'b1;
        tick();
        wait_idle();
        tick();
        chk("R3 byte total", cap.size(), 32'd6);
        chk("R4 partial lane0", {24'h0, cap[4]}, 32'h55);
        chk("R4 partial lane1", {24'h0, cap[5]}, 32'hBE);
        chk("R3 last index", last_idx, 32'd5);
        chk("R5 no req at end", {31'h0, stat_word[31]}, 32'h0);

        // Write with no request pending, then a write while full.
        eng_tx_ready = 1'b0;
        cap.delete();
        start(1'b1, 16'd8);
        clr(1'b1);
        wr(32'h8765_4321);
        repeat (4) tick();
        chk("R8 req held low", {31'h0, stat_word[31]}, 32'h0);
        chk("R8 word held", {31'h0, eng_tx_valid}, 32'h1);
        eng_tx_ready = 1'b1;
        for (int i = 0; i < 20 && !stat_word[31]; i++) tick();
        chk("R8 req after consume", {31'h0, stat_word[31]}, 32'h1);
        eng_tx_ready = 1'b0;
        wr(32'hCAFE_F00D);
        wr(32'h1111_1111);
        tick();
        eng_tx_ready = 1'b1;
        tick();
        wait_idle();
        tick();
        chk("R9 count", cap.size(), 32'd8);
        chk("R9 full write dropped", {24'h0, cap[7]}, 32'hCA);
        wr(32'h5555_5555);
        tick(); tick();
        chk("R9 idle write dropped", {31'h0, eng_tx_valid}, 32'h0);

        // Restart in the middle of a word.
        eng_tx_ready = 1'b0;
        start(1'b1, 16'd12);
        wr(32'h0D0C_0B0A);
        tick(); eng_tx_ready = 1'b1;
        tick(); tick(); eng_tx_ready = 1'b0;
        start(1'b1, 16'd4);
        tick();
        chk("R10 flushed", {31'h0, eng_tx_valid}, 32'h0);
        wr(32'h1413_1211);
        tick();
        chk("R10 lane0 first", {24'h0, eng_tx_byte}, 32'h11);
        eng_tx_ready = 1'b1;
        tick();
        wait_idle();

        // Receive with a colliding clear and bytes past the count.
        start(1'b0, 16'd2);
        tick();
        chk("R11 rx start req", {31'h0, stat_word[31]}, 32'h0);
        rx(8'h5A); clr_wr = 1'b1; clr_bit = 1'b1;
        tick();
        chk("R7 set beats clear", {31'h0, stat_word[31]}, 32'h1);
        chk("R11 low lane", host_rdata, 32'h0000_005A);
        chk("R12 stat word", stat_word, 32'h8000_0000);
        clr(1'b1);
        rx(8'hC3);
        tick();
        clr(1'b0);
        tick();
        chk("R6 clear without bit31", {31'h0, stat_word[31]}, 32'h1);
        clr(1'b1);
        rx(8'h77);
        tick();
        chk("R11 beyond count data", host_rdata, 32'h0000_00C3);
        chk("R11 beyond count req", {31'h0, stat_word[31]}, 32'h0);

        // Random traffic against the model (R2 R4 R6 R7 R9).
        for (int t = 0; t < 40; t++) begin
            start(1'b1, 16'($urandom_range(1, 13)));
            for (int c = 0; c < 60; c++) begin
                tick();
                eng_tx_ready = $urandom_range(0, 2) != 0;
                if ($urandom_range(0, 2) == 0) begin host_wr = 1'b1; host_wdata = $urandom(); end
                if ($urandom_range(0, 3) == 0) begin clr_wr = 1'b1; clr_bit = 1'($urandom()); end
            end
        end
        tick(); tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule